// File: doc/BRIEF.md
# Disk Sector Write Serializer

This block turns one disk sector into the single pulse train that a disk drive's write head expects. A one-cycle `start` pulse raises the write gate, and the block then stays silent for a settling interval. After that it streams a fixed number of records back to back. Each record has a long run of zero cells, a sync pattern, the record's data words and a closing check word. Every bit cell carries a clock pulse at its start. A second pulse in the middle of the cell marks a one bit. After the last record, one silent cell follows, then the gate drops and `done` pulses.

Data words come from a sector buffer over a valid/ready stream. The block raises `wd_ready` during exactly one bit cell before each word is needed. That cell is the last cell of the sync pattern, or the last cell of the word currently being written. The buffer may hold off `wd_valid` for part of that cell. A handshake at any clock edge inside the cell is accepted. A drive head cannot be stalled, so back-pressure ends with the cell. If no handshake has happened by then, the word slot is written and checked as all zeros. The buffer must then drop that word: the next window asks for the following word.

Timing is set from the system clock in MHz and the cell, settle and preamble durations in nanoseconds. The cell length in clocks, the settle length in clocks and the preamble length in bits are all derived from these.

Top module: `sector_write_ser`

## Requirements
- R1: When `start` is high at a clock edge with the block idle, `write_gate` and `busy` are high from the next cycle on, until the end of the sector.
- R2: The first clock pulse on `cell_line` begins exactly SETTLE_CLKS+1 cycles after `write_gate` rises, and the line stays low before it.
- R3: A bit cell lasts CELL_CLKS cycles. `cell_line` is high for PULSE_CLKS cycles from the cell start (clock pulse). It is high again for PULSE_CLKS cycles from cycle CELL_CLKS/2 of the cell only when the bit is 1. It is low at every other time, including whenever the block is idle.
- R4: Each record is sent in this order, with no gap: PRE_BITS zero cells, the SYNC_W-bit sync pattern MSB first (default: a single 1), REC_WORDS data words of WORD_W bits MSB first, then one check word MSB first.
- R5: A sector holds RECORDS records (default 3), sent back to back, each with its own preamble, sync pattern and check word.
- R6: The check word of a record is the XOR of 16'o151 with all of that record's data words. A record of all-zero data therefore carries 0151 octal.
- R7: `wd_ready` is high only in the last cell of the sync pattern and in the last cell of each data word except the record's final one. It rises in the first cycle of that cell and falls in the cycle after a handshake. One word is taken per handshake.
- R8: If no handshake happens in a fetch cell, `wd_ready` falls at the end of the cell, and that word slot is sent, and folded into the check word, as all zeros.
- R9: After the last check bit of the last record, one cell with no pulses follows. Then `write_gate` and `busy` fall, and `done` is high for exactly that one cycle.
- R10: A `start` pulse while `busy` is high has no effect on the current sector and does not begin another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin writing one sector (ignored while busy) |
| wd_valid | input | 1 | Sector buffer offers a data word |
| wd_ready | output | 1 | Block accepts a data word this cycle |
| wd_data | input | WORD_W | Data word from the sector buffer |
| write_gate | output | 1 | Write enable to the drive |
| cell_line | output | 1 | Combined clock and data pulse line |
| busy | output | 1 | Sector write in progress |
| done | output | 1 | One-cycle pulse at the end of the sector |

## Verification
The bench builds the block with a 50 MHz clock and durations of 160 ns per cell, 200 ns of settle and 3200 ns of preamble. This gives 8-cycle cells, a 10-cycle settle and a 20-cell preamble. With these values, a whole three-record sector is only a few hundred cells long. Several full sectors therefore fit in one run: all-zero data, mixed data with a stray start pulse, a buffer that answers late in its fetch cell, and a buffer that misses a fetch cell entirely. The per-clock model checks every pulse position. A line decoder also recovers the bits, so preamble length, sync position and the check word are checked as values.

// File: rtl/swr_pkg.sv
package swr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_PRE,
    ST_SYNC,
    ST_DATA,
    ST_CK,
    ST_TAIL
  } swr_state_e;
endpackage

// File: rtl/swr_cell_timer.sv
module swr_cell_timer #(
  parameter int CELL_CLKS = 30,
  parameter int PW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [PW-1:0] phase,
  output logic          cell_end
);
  localparam logic [PW-1:0] PH_LAST = PW'(CELL_CLKS - 1);

  assign cell_end = run && (phase == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase <= '0;
    else if (!run || cell_end) phase <= '0;
    else                       phase <= phase + 1'b1;
  end
endmodule

// File: rtl/swr_line_enc.sv
module swr_line_enc #(
  parameter int CELL_CLKS  = 30,
  parameter int PULSE_CLKS = 7,
  parameter int PW         = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          emit,
  input  logic          bit_val,
  input  logic [PW-1:0] phase,
  output logic          line
);
  localparam logic [PW-1:0] CLK_END  = PW'(PULSE_CLKS);
  localparam logic [PW-1:0] DAT_BEG  = PW'(CELL_CLKS / 2);
  localparam logic [PW-1:0] DAT_END  = PW'(CELL_CLKS / 2 + PULSE_CLKS);

  logic clk_pulse, dat_pulse;

  always_comb begin
    clk_pulse = phase < CLK_END;
    dat_pulse = bit_val && (phase >= DAT_BEG) && (phase < DAT_END);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line <= 1'b0;
    else        line <= emit && (clk_pulse || dat_pulse);
  end
endmodule

// File: rtl/swr_word_path.sv
module swr_word_path #(
  parameter int                WORD_W  = 16,
  parameter logic [WORD_W-1:0] CK_SEED = 16'o151
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_win,
  input  logic              load_word,
  input  logic              load_ck,
  input  logic              shift_en,
  input  logic              seed,
  input  logic              wd_valid,
  input  logic [WORD_W-1:0] wd_data,
  output logic              wd_ready,
  output logic              msb
);
  logic [WORD_W-1:0] sh, cks, nxt, incoming;
  logic              have_nxt, take;

  assign wd_ready = fetch_win && !have_nxt;
  assign take     = wd_ready && wd_valid;
  assign msb      = sh[WORD_W-1];

  always_comb begin
    if (take)          incoming = wd_data;
    else if (have_nxt) incoming = nxt;
    else               incoming = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      cks      <= CK_SEED;
      nxt      <= '0;
      have_nxt <= 1'b0;
    end else begin
      if (load_word) begin
        sh       <= incoming;
        cks      <= cks ^ incoming;
        have_nxt <= 1'b0;
      end else begin
        if (take) begin
          nxt      <= wd_data;
          have_nxt <= 1'b1;
        end
        if (load_ck)       sh <= cks;
        else if (shift_en) sh <= sh << 1;
      end
      if (seed) cks <= CK_SEED;
    end
  end
endmodule

// File: rtl/sector_write_ser.sv
module sector_write_ser
  import swr_pkg::*;
#(
  parameter int                WORD_W    = 16,
  parameter int                REC_WORDS = 2,
  parameter int                RECORDS   = 3,
  parameter int                SYNC_W    = 1,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 1'b1,
  parameter logic [WORD_W-1:0] CK_SEED   = 16'o151,
  parameter int                CLK_MHZ   = 50,
  parameter int                CELL_NS   = 600,
  parameter int                SETTLE_NS = 2000,
  parameter int                PRE_NS    = 337000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [WORD_W-1:0] wd_data,
  output logic              write_gate,
  output logic              cell_line,
  output logic              busy,
  output logic              done
);
  localparam int CELL_CLKS   = CLK_MHZ * CELL_NS / 1000;
  localparam int SETTLE_CLKS = CLK_MHZ * SETTLE_NS / 1000;
  localparam int PRE_BITS    = PRE_NS / CELL_NS;
  localparam int PULSE_CLKS  = (CELL_CLKS / 4 > 0) ? CELL_CLKS / 4 : 1;
  localparam int PW          = $clog2(CELL_CLKS);
  localparam int M1          = (SETTLE_CLKS > PRE_BITS) ? SETTLE_CLKS : PRE_BITS;
  localparam int M2          = (WORD_W > SYNC_W) ? WORD_W : SYNC_W;
  localparam int CW          = $clog2(((M1 > M2) ? M1 : M2) + 1);
  localparam int WX          = $clog2(REC_WORDS + 1);
  localparam int RX          = $clog2(RECORDS + 1);

  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CLKS - 1);
  localparam logic [CW-1:0] PRE_LAST    = CW'(PRE_BITS - 1);
  localparam logic [CW-1:0] SYNC_LAST   = CW'(SYNC_W - 1);
  localparam logic [CW-1:0] WORD_LAST   = CW'(WORD_W - 1);
  localparam logic [WX-1:0] WIX_LAST    = WX'(REC_WORDS - 1);
  localparam logic [RX-1:0] RIX_LAST    = RX'(RECORDS - 1);

  swr_state_e        state;
  logic [CW-1:0]     cnt;
  logic [WX-1:0]     widx;
  logic [RX-1:0]     ridx;
  logic [SYNC_W-1:0] sync_sh;
  logic              done_q;

  logic [PW-1:0] phase;
  logic          cell_end, msb, emit, run, last_bit, cur_bit;
  logic          fetch_win, load_word, load_ck, shift_en, seed;

  always_comb begin
    emit = (state == ST_PRE) || (state == ST_SYNC) ||
           (state == ST_DATA) || (state == ST_CK);
    run  = emit || (state == ST_TAIL);
    case (state)
      ST_PRE:        last_bit = (cnt == PRE_LAST);
      ST_SYNC:       last_bit = (cnt == SYNC_LAST);
      ST_DATA, ST_CK: last_bit = (cnt == WORD_LAST);
      default:       last_bit = 1'b0;
    endcase
    case (state)
      ST_SYNC:       cur_bit = sync_sh[SYNC_W-1];
      ST_DATA, ST_CK: cur_bit = msb;
      default:       cur_bit = 1'b0;
    endcase
    fetch_win = ((state == ST_SYNC) && last_bit) ||
                ((state == ST_DATA) && last_bit && (widx != WIX_LAST));
    load_word = cell_end && fetch_win;
    load_ck   = cell_end && (state == ST_DATA) && last_bit && (widx == WIX_LAST);
    shift_en  = cell_end && ((state == ST_DATA) || (state == ST_CK)) && !last_bit;
    seed      = ((state == ST_SETTLE) && (cnt == SETTLE_LAST)) ||
                ((state == ST_CK) && cell_end && last_bit && (ridx != RIX_LAST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      widx    <= '0;
      ridx    <= '0;
      sync_sh <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_SETTLE;
          cnt   <= '0;
        end
        ST_SETTLE: if (cnt == SETTLE_LAST) begin
          state <= ST_PRE;
          cnt   <= '0;
          ridx  <= '0;
        end else cnt <= cnt + 1'b1;
        ST_TAIL: if (cell_end) begin
          state  <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: if (cell_end) begin
          if (state == ST_SYNC) sync_sh <= sync_sh << 1;
          if (!last_bit) cnt <= cnt + 1'b1;
          else begin
            cnt <= '0;
            case (state)
              ST_PRE: begin
                state   <= ST_SYNC;
                sync_sh <= SYNC_WORD;
              end
              ST_SYNC: begin
                state <= ST_DATA;
                widx  <= '0;
              end
              ST_DATA: if (widx == WIX_LAST) state <= ST_CK;
                       else widx <= widx + 1'b1;
              ST_CK: if (ridx == RIX_LAST) state <= ST_TAIL;
                     else begin
                       state <= ST_PRE;
                       ridx  <= ridx + 1'b1;
                     end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign write_gate = busy;
  assign done       = done_q;

  swr_cell_timer #(.CELL_CLKS(CELL_CLKS), .PW(PW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .phase(phase), .cell_end(cell_end)
  );

  swr_word_path #(.WORD_W(WORD_W), .CK_SEED(CK_SEED)) u_words (
    .clk(clk), .rst_n(rst_n), .fetch_win(fetch_win), .load_word(load_word),
    .load_ck(load_ck), .shift_en(shift_en), .seed(seed), .wd_valid(wd_valid),
    .wd_data(wd_data), .wd_ready(wd_ready), .msb(msb)
  );

  swr_line_enc #(.CELL_CLKS(CELL_CLKS), .PULSE_CLKS(PULSE_CLKS), .PW(PW)) u_enc (
    .clk(clk), .rst_n(rst_n), .emit(emit), .bit_val(cur_bit), .phase(phase),
    .line(cell_line)
  );
endmodule

// File: rtl/swr_checker.sv
module swr_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic write_gate,
  input logic cell_line,
  input logic busy,
  input logic done,
  input logic wd_ready
);
  AST_START_GATE:   assert property (@(posedge clk) disable iff (!rst_n) start && !busy |=> write_gate); // R1
  AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $rose(write_gate) |=> !cell_line); // R2
  AST_IDLE_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !cell_line); // R3
  AST_READY_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) wd_ready |-> busy); // R7
  AST_DONE_ONCE:    assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) done |-> $fell(write_gate)); // R9
  AST_FALL_HAS_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(write_gate) |-> done); // R9
endmodule

bind sector_write_ser swr_checker u_swr_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .write_gate(write_gate),
  .cell_line(cell_line), .busy(busy), .done(done), .wd_ready(wd_ready)
);

// File: tb/test_sector_write_ser.sv
module test_sector_write_ser;
  localparam int CELL   = 8;
  localparam int HALF   = CELL / 2;
  localparam int PULSE  = CELL / 4;
  localparam int SETTLE = 10;
  localparam int PRE    = 20;
  localparam int W      = 16;
  localparam int NW     = 2;
  localparam int NR     = 3;
  localparam int SW     = 1;
  localparam int REC    = PRE + SW + NW * W + W;
  localparam int TB     = NR * REC;
  localparam int END_N  = SETTLE + (TB + 1) * CELL;

  logic clk = 0, rst_n = 0, start = 0, wd_valid = 0;
  logic [W-1:0] wd_data = '0;
  logic wd_ready, write_gate, cell_line, busy, done;

  always #10 clk = ~clk;

  sector_write_ser #(.CLK_MHZ(50), .CELL_NS(160), .SETTLE_NS(200), .PRE_NS(3200)) i_sector_write_ser (
    .clk(clk), .rst_n(rst_n), .start(start), .wd_valid(wd_valid), .wd_ready(wd_ready),
    .wd_data(wd_data), .write_gate(write_gate), .cell_line(cell_line), .busy(busy), .done(done)
  );

  int checks = 0, fails = 0;
  logic [W-1:0] words [NR*NW];
  bit gap [NR*NW];
  bit ref_bits [TB];
  logic [W-1:0] ref_ck [NR];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // reference model, advanced on every clock
  bit m_run = 0, m_taken = 0;
  int n = 0;

  function automatic bit is_fetch(input int c);
    int r = c % REC;
    if (r == PRE + SW - 1) return 1;
    if (r >= PRE + SW && r < PRE + SW + (NW - 1) * W && ((r - PRE - SW) % W) == W - 1) return 1;
    return 0;
  endfunction

  function automatic bit exp_ready();
    int s = n - SETTLE;
    if (!m_run || s < 0 || s >= TB * CELL) return 0;
    return is_fetch(s / CELL) && !m_taken;
  endfunction

  function automatic bit exp_line();
    int s = n - 1 - SETTLE;
    int ph;
    if (!m_run || s < 0 || s >= TB * CELL) return 0;
    ph = s % CELL;
    return (ph < PULSE) || (ref_bits[s / CELL] && ph >= HALF && ph < HALF + PULSE);
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      if (start && !(m_run && n < END_N)) begin
        m_run = 1; n = 0; m_taken = 0;
      end else if (m_run) begin
        if (exp_ready() && wd_valid) m_taken = 1;
        n++;
        if (n >= SETTLE && ((n - SETTLE) % CELL) == 0) m_taken = 0;
      end
    end
  end

  // buffer source: one window per rise of wd_ready
  bit src_on = 0, rdy_seen = 0, src_tk = 0;
  int win = 0, wcyc = 0, lag = 0;
  always @(negedge clk) begin
    if (!src_on) begin
      wd_valid <= 0;
    end else begin
      if (wd_valid && rdy_seen) src_tk = 1;
      if (wd_ready && !rdy_seen) begin win++; wcyc = 0; src_tk = 0; end
      else wcyc++;
      rdy_seen = wd_ready;
      if (win > 0 && win <= NR * NW) begin
        wd_valid <= wd_ready && !src_tk && !gap[win-1] && wcyc >= lag;
        wd_data  <= words[win-1];
      end else wd_valid <= 0;
    end
  end

  // per-clock comparison and line decoder
  bit dec_q [$];
  bit dec_on = 0, dec_cur = 0, prev_line = 0, prev_gate = 0;
  int cyc = 0, last_clk = 0, gate_rise = 0, first_rise = -1;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(write_gate == (m_run && n < END_N), "R1", "write_gate", write_gate, m_run && n < END_N);
      chk(busy == (m_run && n < END_N), "R1", "busy", busy, m_run && n < END_N);
      chk(done == (m_run && n == END_N), "R9", "done", done, m_run && n == END_N);
      chk(cell_line == exp_line(), "R3", "cell_line", cell_line, exp_line());
      chk(wd_ready == exp_ready(), "R7", "wd_ready", wd_ready, exp_ready());
      if (write_gate && !prev_gate) begin gate_rise = cyc; first_rise = -1; end
      if (cell_line && !prev_line) begin
        if (first_rise < 0) first_rise = cyc;
        if (!dec_on) begin dec_on = 1; dec_cur = 0; last_clk = cyc; end
        else if (cyc - last_clk == HALF) dec_cur = 1;
        else begin dec_q.push_back(dec_cur); dec_cur = 0; last_clk = cyc; end
      end
      if (done && dec_on) begin dec_q.push_back(dec_cur); dec_on = 0; end
      prev_line = cell_line;
      prev_gate = write_gate;
    end
  end

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog R9: actual %0d cycles expected below 150000", wd_cnt);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [W-1:0] dec_word(input int at);
    logic [W-1:0] v = '0;
    for (int b = 0; b < W; b++) v = {v[W-2:0], logic'(dec_q[at + b])};
    return v;
  endfunction

  task automatic build_ref();
    int k = 0;
    for (int r = 0; r < NR; r++) begin
      logic [W-1:0] ck = 16'o151;
      for (int b = 0; b < PRE; b++) ref_bits[k++] = 0;
      ref_bits[k++] = 1;
      for (int w = 0; w < NW; w++) begin
        logic [W-1:0] v = gap[r*NW+w] ? '0 : words[r*NW+w];
        ck ^= v;
        for (int b = W - 1; b >= 0; b--) ref_bits[k++] = v[b];
      end
      ref_ck[r] = ck;
      for (int b = W - 1; b >= 0; b--) ref_bits[k++] = ck[b];
    end
  endtask

  task automatic run_sector(input int kind, input int lag_i, input int gap_i, input int mid_start);
    int bad = 0;
    for (int i = 0; i < NR * NW; i++) begin
      words[i] = (kind == 0) ? '0 : W'((i * 7919 + 23100) ^ (i << 11));
      gap[i]   = (i == gap_i);
    end
    build_ref();
    dec_q.delete();
    lag = lag_i; win = 0; src_on = 1; rdy_seen = 0; src_tk = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    if (mid_start > 0) begin
      repeat (mid_start) @(negedge clk);
      start = 1;
      @(negedge clk) start = 0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(first_rise - gate_rise == SETTLE + 1, "R2", "settle cycles to first pulse", first_rise - gate_rise, SETTLE + 1);
    chk(dec_q.size() == TB, "R5", "decoded cell count", dec_q.size(), TB);
    if (dec_q.size() == TB) begin
      for (int i = 0; i < TB; i++) if (dec_q[i] != ref_bits[i]) bad++;
      chk(bad == 0, "R4", "decoded bit mismatches", bad, 0);
      for (int r = 0; r < NR; r++) begin
        int first_one = -1;
        for (int i = 0; i < REC && first_one < 0; i++) if (dec_q[r*REC+i]) first_one = i;
        chk(first_one == PRE, "R4", "sync position after preamble", first_one, PRE);
        chk(dec_word(r*REC + REC - W) == ref_ck[r], "R6", "check word", dec_word(r*REC + REC - W), ref_ck[r]);
        if (kind == 0)
          chk(dec_word(r*REC + REC - W) == 16'o151, "R6", "zero-data check word", dec_word(r*REC + REC - W), 16'o151);
      end
      if (gap_i >= 0) begin
        int at = (gap_i / NW) * REC + PRE + SW + (gap_i % NW) * W;
        chk(dec_word(at) == 0, "R8", "missed word written as zero", dec_word(at), 0);
      end
    end
    if (mid_start > 0) chk(write_gate == 0 && busy == 0, "R10", "no second sector after stray start", write_gate, 0);
    src_on = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NR * NW; i++) begin words[i] = '0; gap[i] = 0; end
    repeat (3) @(negedge clk);
    chk(write_gate == 0, "R1", "reset write_gate", write_gate, 0);
    chk(cell_line == 0, "R3", "reset cell_line", cell_line, 0);
    chk(busy == 0 && done == 0, "R9", "reset busy/done", busy | done, 0);
    chk(wd_ready == 0, "R7", "reset wd_ready", wd_ready, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_sector(0, 0, -1, 0);
    run_sector(1, 0, -1, 400);
    run_sector(1, 3, -1, 0);
    run_sector(1, 0, 3, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule